// File: doc/BRIEF.md
# Interrupt Request Flag Register with Deferred Stage

This block holds the interrupt request flags of a small processor: five request bits, one for each interrupt source. Sources raise a request in one of two ways. An immediate request sets its flag bit at the next clock edge. A deferred request is parked in a separate one-cycle stage and becomes a real flag only when that stage is merged. The stage is merged in two cases. The whole stage is merged on a processor step strobe. Individual bits are merged on the owning source's own fold strobe, for example when a display or timer unit reaches its own step.

The processor reads and writes the flag register through a simple port. A read shows both the flags and the parked bits. The three unused high bits always read as one. A write stores new flag values and throws away everything still parked in the stage.

The block combines the flags with the enable mask into a serviceable set. While the processor runs, parked bits already count as serviceable. While it is halted, they do not count. A non-empty serviceable set raises a wake signal that ends the halt. A priority encoder reports the lowest-numbered serviceable source. Vector dispatch and instruction sequencing stay outside.

Top module: `irq_flag_unit`

## Requirements
- R1: After reset, every flag bit and every parked bit is zero. The read port shows 0xE0, the serviceable set is zero, and wake and the top-valid output are low.
- R2: The read port returns bits 7..5 as ones. Bit n (n = 0..4) is the OR of flag bit n and parked bit n, and bit n belongs to source n.
- R3: While `halted` is high, the serviceable set equals the enable mask ANDed with the flag bits only. Parked bits are excluded.
- R4: While `halted` is low, the serviceable set equals the enable mask ANDed with the OR of the flag bits and the parked bits.
- R5: When `cpu_step` is high and no write occurs, every parked bit moves into the flags at the next edge and the stage empties.
- R6: A bit of `src_fold` moves only that source's parked bit into the flags. Other parked bits stay parked.
- R7: A processor write stores `cpu_wr_data[4:0]` into the flags and empties the whole stage. Parked bits are not merged in that cycle, even if a step or a fold strobe is also present.
- R8: An immediate request sets its flag bit at the next edge. It wins over a processor write that clears the same bit in the same cycle.
- R9: A deferred request appears as a parked bit at the next edge. This holds even when the same cycle carries a fold, a step or a processor write.
- R10: `wake` is high exactly when the serviceable set is non-zero.
- R11: `irq_top_valid` is high when the serviceable set is non-zero. `irq_top_id` then gives the lowest-numbered serviceable bit, where bit 0 has the highest priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr_en | input | 1 | Processor write strobe for the flag register |
| cpu_wr_data | input | 8 | Write data; bits 4..0 are used |
| cpu_rd_data | output | 8 | Read view: high bits as ones, flags OR parked bits |
| ie_mask | input | 5 | Interrupt enable mask |
| req_direct | input | 5 | Immediate request per source |
| req_defer | input | 5 | Deferred request per source into the parked stage |
| src_fold | input | 5 | Per-source strobe that merges that source's parked bit |
| cpu_step | input | 1 | Processor step; merges the whole parked stage |
| halted | input | 1 | Processor is halted |
| irq_pending | output | 5 | Serviceable set |
| irq_top_id | output | 3 | Index of the lowest serviceable bit |
| irq_top_valid | output | 1 | Serviceable set is non-empty |
| wake | output | 1 | Request to leave the halt state |

## Verification
Random cycles draw sparse immediate requests, deferred requests, fold strobes, steps, writes and enable masks. The `halted` input is toggled along the way. Comparing the serviceable set under both halt states tells whether parked bits are correctly counted or ignored.

Directed sequences isolate the cases that random data rarely produces:
- A write in the same cycle as an immediate request to the same bit separates the write-versus-request priority.
- A write while bits are parked separates flushing the stage from merging it.
- A deferred request arriving together with a fold shows whether new arrivals survive the merge.
- A per-source fold next to a second parked bit shows that the fold touches only its own bit.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;

  localparam int unsigned SRC_N  = 5;
  localparam int unsigned BUS_W  = 8;

  // Mask with the lowest n bits set, limited to 32 bits.
  function automatic logic [31:0] low_ones(input int unsigned n);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < 32; i++) begin
      if (i < n) m[i] = 1'b1;
    end
    return m;
  endfunction

  // Index of the lowest set bit of v, or 0 when v is empty.
  function automatic int unsigned lowest_set(input logic [31:0] v);
    int unsigned idx;
    idx = 0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i]) idx = i;
    end
    return idx;
  endfunction

endpackage

// File: rtl/ifr_pend_stage.sv
module ifr_pend_stage #(
  parameter int unsigned N = irq_flag_pkg::SRC_N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] post,
  input  logic [N-1:0] fold,
  input  logic         flush,
  output logic [N-1:0] pend_q
);

  // One parked bit per source; a new post always survives the same-cycle
  // fold or flush.
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) pend_q[i] <= 1'b0;
      else        pend_q[i] <= post[i] | (~flush & pend_q[i] & ~fold[i]);
    end
  end

endmodule

// File: rtl/ifr_flag_reg.sv
module ifr_flag_reg #(
  parameter int unsigned N = irq_flag_pkg::SRC_N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [N-1:0] wdata,
  input  logic [N-1:0] merge,
  input  logic [N-1:0] set,
  output logic [N-1:0] flag_q
);

  // Write replaces the base value; merged and immediate bits are ORed on top.
  function automatic logic [N-1:0] next_flags(
    input logic         w,
    input logic [N-1:0] d,
    input logic [N-1:0] cur,
    input logic [N-1:0] mrg,
    input logic [N-1:0] s
  );
    logic [N-1:0] base;
    base = w ? d : cur;
    return base | mrg | s;
  endfunction

  logic [N-1:0] flag_d;

  always_comb flag_d = next_flags(wr, wdata, flag_q, merge, set);

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

endmodule

// File: rtl/ifr_prio_enc.sv
module ifr_prio_enc #(
  parameter int unsigned N    = irq_flag_pkg::SRC_N,
  parameter int unsigned ID_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    vec,
  output logic [ID_W-1:0] id,
  output logic            valid
);

  logic [31:0] wide;

  always_comb begin
    wide  = 32'(vec);
    id    = ID_W'(irq_flag_pkg::lowest_set(wide));
    valid = |vec;
  end

endmodule

// File: rtl/irq_flag_unit.sv
module irq_flag_unit #(
  parameter int unsigned NUM_SRC = irq_flag_pkg::SRC_N,
  parameter int unsigned DATA_W  = irq_flag_pkg::BUS_W,
  parameter int unsigned ID_W    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_wr_en,
  input  logic [DATA_W-1:0]  cpu_wr_data,
  output logic [DATA_W-1:0]  cpu_rd_data,
  input  logic [NUM_SRC-1:0] ie_mask,
  input  logic [NUM_SRC-1:0] req_direct,
  input  logic [NUM_SRC-1:0] req_defer,
  input  logic [NUM_SRC-1:0] src_fold,
  input  logic               cpu_step,
  input  logic               halted,
  output logic [NUM_SRC-1:0] irq_pending,
  output logic [ID_W-1:0]    irq_top_id,
  output logic               irq_top_valid,
  output logic               wake
);

  localparam int unsigned PAD_W = DATA_W - NUM_SRC;

  // Named internal events, visible to the bound checker.
  logic [NUM_SRC-1:0] flag_q;
  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] fold_mask;
  logic [NUM_SRC-1:0] merge_bits;
  logic [NUM_SRC-1:0] visible_pend;

  always_comb begin
    fold_mask    = cpu_step ? {NUM_SRC{1'b1}} : src_fold;
    merge_bits   = cpu_wr_en ? '0 : (pend_q & fold_mask);
    visible_pend = halted ? '0 : pend_q;
  end

  ifr_pend_stage #(.N(NUM_SRC)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .post   (req_defer),
    .fold   (fold_mask),
    .flush  (cpu_wr_en),
    .pend_q (pend_q)
  );

  ifr_flag_reg #(.N(NUM_SRC)) u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (cpu_wr_en),
    .wdata  (cpu_wr_data[NUM_SRC-1:0]),
    .merge  (merge_bits),
    .set    (req_direct),
    .flag_q (flag_q)
  );

  always_comb begin
    irq_pending = ie_mask & (flag_q | visible_pend);
    wake        = |irq_pending;
    cpu_rd_data = {{PAD_W{1'b1}}, flag_q | pend_q};
  end

  ifr_prio_enc #(.N(NUM_SRC), .ID_W(ID_W)) u_prio (
    .vec   (irq_pending),
    .id    (irq_top_id),
    .valid (irq_top_valid)
  );

endmodule

// File: rtl/irq_flag_unit_chk.sv
module irq_flag_unit_chk #(
  parameter int unsigned NUM_SRC = 5,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned ID_W    = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cpu_wr_en,
  input logic               cpu_step,
  input logic               halted,
  input logic [NUM_SRC-1:0] req_direct,
  input logic [NUM_SRC-1:0] req_defer,
  input logic [NUM_SRC-1:0] flag_q,
  input logic [NUM_SRC-1:0] pend_q,
  input logic [NUM_SRC-1:0] irq_pending,
  input logic [ID_W-1:0]    irq_top_id,
  input logic               irq_top_valid,
  input logic               wake,
  input logic [DATA_W-1:0]  cpu_rd_data
);

  localparam int unsigned PAD_W = DATA_W - NUM_SRC;

  logic               past_ok;
  logic [NUM_SRC-1:0] below_top;
  logic [NUM_SRC-1:0] top_bit;

  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  always_comb begin
    top_bit   = NUM_SRC'(1) << irq_top_id;
    below_top = top_bit - NUM_SRC'(1);
  end

  assert_rd_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd_data[DATA_W-1:NUM_SRC] == {PAD_W{1'b1}});

  assert_halt_hides_R3: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> ((irq_pending & ~flag_q) == '0));

  assert_step_merge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(cpu_step) && !$past(cpu_wr_en))
      |-> ((flag_q & $past(pend_q)) == $past(pend_q)));

  assert_wr_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(cpu_wr_en)) |-> (pend_q == $past(req_defer)));

  assert_direct_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((flag_q & $past(req_direct)) == $past(req_direct)));

  assert_defer_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((pend_q & $past(req_defer)) == $past(req_defer)));

  assert_wake_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wake == (irq_pending != '0));

  assert_top_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_top_valid |-> (((irq_pending & top_bit) != '0)
                       && ((irq_pending & below_top) == '0)));

endmodule

bind irq_flag_unit irq_flag_unit_chk #(
  .NUM_SRC (NUM_SRC),
  .DATA_W  (DATA_W),
  .ID_W    (ID_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cpu_wr_en     (cpu_wr_en),
  .cpu_step      (cpu_step),
  .halted        (halted),
  .req_direct    (req_direct),
  .req_defer     (req_defer),
  .flag_q        (flag_q),
  .pend_q        (pend_q),
  .irq_pending   (irq_pending),
  .irq_top_id    (irq_top_id),
  .irq_top_valid (irq_top_valid),
  .wake          (wake),
  .cpu_rd_data   (cpu_rd_data)
);

// File: tb/sim_irq_flag_unit.sv
module sim_irq_flag_unit;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_wr_en = 1'b0;
  logic [7:0] cpu_wr_data = '0;
  logic [7:0] cpu_rd_data;
  logic [4:0] ie_mask = '0;
  logic [4:0] req_direct = '0;
  logic [4:0] req_defer = '0;
  logic [4:0] src_fold = '0;
  logic       cpu_step = 1'b0;
  logic       halted = 1'b0;
  logic [4:0] irq_pending;
  logic [2:0] irq_top_id;
  logic       irq_top_valid;
  logic       wake;

  int checks = 0;
  int errors = 0;

  logic [4:0] m_if = '0;
  logic [4:0] m_pend = '0;

  always #(CLK_P/2) clk = ~clk;

  irq_flag_unit u0 (
    .clk(clk), .rst_n(rst_n), .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data),
    .cpu_rd_data(cpu_rd_data), .ie_mask(ie_mask), .req_direct(req_direct),
    .req_defer(req_defer), .src_fold(src_fold), .cpu_step(cpu_step),
    .halted(halted), .irq_pending(irq_pending), .irq_top_id(irq_top_id),
    .irq_top_valid(irq_top_valid), .wake(wake)
  );

  function automatic logic [4:0] exp_svc(input logic [4:0] f, input logic [4:0] p,
                                         input logic [4:0] ie, input logic h);
    logic [4:0] seen;
    seen = h ? f : (f | p);
    return seen & ie;
  endfunction

  function automatic int exp_top(input logic [4:0] s);
    for (int i = 0; i < 5; i++) if (s[i]) return i;
    return 0;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_model();
    logic [4:0] s;
    s = exp_svc(m_if, m_pend, ie_mask, halted);
    check("R2 read view", cpu_rd_data, {3'b111, m_if | m_pend});
    check(halted ? "R3 halted set" : "R4 running set", irq_pending, s);
    check("R10 wake", wake, s != 0);
    check("R11 top valid", irq_top_valid, s != 0);
    if (s != 0) check("R11 top id", irq_top_id, exp_top(s));
  endtask

  task automatic apply(input logic wr, input logic [7:0] wd, input logic [4:0] dir,
                       input logic [4:0] def, input logic [4:0] fold,
                       input logic step, input logic h, input logic [4:0] ie);
    @(negedge clk);
    cpu_wr_en = wr; cpu_wr_data = wd; req_direct = dir; req_defer = def;
    src_fold = fold; cpu_step = step; halted = h; ie_mask = ie;
    #2;
    compare_model();
  endtask

  task automatic adv();
    logic [4:0] fm;
    @(posedge clk);
    fm = cpu_step ? 5'h1f : src_fold;
    if (cpu_wr_en) begin
      m_if   = cpu_wr_data[4:0] | req_direct;
      m_pend = req_defer;
    end else begin
      m_if   = m_if | (m_pend & fm) | req_direct;
      m_pend = (m_pend & ~fm) | req_defer;
    end
  endtask

  task automatic idle(input logic h, input logic [4:0] ie);
    apply(1'b0, 8'h00, 5'h0, 5'h0, 5'h0, 1'b0, h, ie);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    idle(1'b0, 5'h1f);
    check("R1 reset read", cpu_rd_data, 8'hE0);
    check("R1 reset pending", irq_pending, 0);
    check("R1 reset wake", wake, 0);
    adv();

    // R9 then R3/R4/R5: defer bit 2, view it halted and running, then step
    apply(1'b0, 8'h00, 5'h0, 5'h04, 5'h0, 1'b0, 1'b1, 5'h1f); adv();
    idle(1'b1, 5'h1f);
    check("R9 defer visible", cpu_rd_data, 8'hE4);
    check("R3 halted hides parked", irq_pending, 0);
    idle(1'b0, 5'h1f);
    check("R4 running shows parked", irq_pending, 5'h04);
    apply(1'b0, 8'h00, 5'h0, 5'h0, 5'h0, 1'b1, 1'b0, 5'h1f); adv();
    idle(1'b1, 5'h1f);
    check("R5 step merged", irq_pending, 5'h04);
    apply(1'b1, 8'h00, 5'h0, 5'h0, 5'h0, 1'b0, 1'b1, 5'h1f); adv();

    // R6: fold only source 0 while bit 1 is parked
    apply(1'b0, 8'h00, 5'h0, 5'h03, 5'h0, 1'b0, 1'b1, 5'h1f); adv();
    apply(1'b0, 8'h00, 5'h0, 5'h0, 5'h01, 1'b0, 1'b1, 5'h1f); adv();
    idle(1'b1, 5'h1f);
    check("R6 own fold only", irq_pending, 5'h01);
    apply(1'b0, 8'h00, 5'h0, 5'h0, 5'h02, 1'b0, 1'b1, 5'h1f); adv();
    idle(1'b1, 5'h1f);
    check("R6 second fold", irq_pending, 5'h03);

    // R7: write with step while bit 3 parked -> stage discarded
    apply(1'b0, 8'h00, 5'h0, 5'h08, 5'h0, 1'b0, 1'b0, 5'h1f); adv();
    apply(1'b1, 8'hE1, 5'h0, 5'h0, 5'h0, 1'b1, 1'b0, 5'h1f); adv();
    idle(1'b0, 5'h1f);
    check("R7 write flushes stage", cpu_rd_data, 8'hE1);

    // R8: write clearing bit 4 loses to an immediate request on bit 4
    apply(1'b1, 8'h00, 5'h10, 5'h0, 5'h0, 1'b0, 1'b0, 5'h1f); adv();
    idle(1'b1, 5'h1f);
    check("R8 direct beats write", cpu_rd_data, 8'hF0);

    // R9: new deferred bit 0 survives a same-cycle step
    apply(1'b0, 8'h00, 5'h0, 5'h01, 5'h0, 1'b1, 1'b1, 5'h1f); adv();
    idle(1'b1, 5'h1f);
    check("R9 survives step read", cpu_rd_data, 8'hF1);
    check("R9 survives step halted", irq_pending, 5'h10);
    // R11: lowest bit wins once bit 0 merges
    apply(1'b0, 8'h00, 5'h0, 5'h0, 5'h0, 1'b1, 1'b1, 5'h1f); adv();
    idle(1'b1, 5'h1f);
    check("R11 lowest wins", irq_top_id, 0);

    // Random phase
    void'($urandom(32'd4242));
    for (int n = 0; n < 3000; n++) begin
      logic wr;
      logic [4:0] dir, def, fold;
      wr   = ($urandom % 12) == 0;
      dir  = 5'($urandom) & 5'($urandom) & 5'($urandom);
      def  = 5'($urandom) & 5'($urandom);
      fold = 5'($urandom) & 5'($urandom);
      apply(wr, 8'($urandom), dir, def, fold, ($urandom % 5) == 0,
            ($urandom % 3) == 0, 5'($urandom));
      adv();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule